// File: doc/BRIEF.md
# Serial Peripheral Master with Frame CRC

This block is a serial peripheral interface master held in a small register file. A host writes a control word, a polynomial and data words through a simple strobe interface (write enable, read enable, address, write data, registered read data). Each data word it writes lands in a one-entry transmit buffer. When the block is enabled in the master role, it moves that word into a shift register. It then clocks the word out on MOSI while it samples MISO, with the active-low chip select held low for the whole frame.

The serial clock runs at the system clock divided by a power of two from 2 to 256, picked by a 3-bit code. A frame is 8 or 16 bits. The received word goes to a receive buffer that shares the data address with the transmit buffer but is separate storage. Two CRC accumulators, one for each direction, run bit by bit over the frames with a programmable polynomial. An interrupt line, gated by a control bit, reports that the transmit buffer is free.

Register map (address: content). 0 holds control: bit0 master role, bit1 enable, bits 4:2 clock code, bit5 16-bit frames, bit6 interrupt enable. 1 holds status, which is read-only: bit0 transmit buffer empty (TXE), bit1 receive buffer full (RXNE), bit2 frame in progress. 2 is data. 3 is the polynomial. 4 is the receive CRC and 5 the transmit CRC, both read-only.

Top module: `spi_crc_master`

## Requirements
- R1: After reset, control reads 0x0000, the polynomial reads 0x0007, status reads 0x0001 (TXE=1, RXNE=0), both CRCs read 0, cs_n=1, sck=0 and irq=0.
- R2: Control bits 4:2 hold a code c from 0 to 7. During a frame the SCK period is 2^(c+1) system clocks, and SCK idles low.
- R3: No frame starts unless control bit0 (master) and bit1 (enable) are both 1. Until then a written word stays buffered (status bit0 stays 0), and cs_n stays 1 and sck stays 0.
- R4: Data shifts MSB first. MOSI changes only on falling SCK edges, and MISO is sampled on rising edges. cs_n is low from before the first rising edge until after the last falling edge.
- R5: Control bit5=0 gives 8-bit frames (8 SCK pulses, data bits 7:0). Bit5=1 gives 16-bit frames (16 pulses).
- R6: A read of address 2 returns the last received frame, zero-extended in 8-bit mode, and never the word written there.
- R7: When a buffered word moves into the shifter, TXE sets again. A second word written then is sent as the next frame.
- R8: At the end of each frame RXNE sets. A read of address 2 clears it.
- R9: Each CRC starts at 0 and is updated once per bit, MSB first, over the frame width in use (8 or 16 bits): feedback = CRC top bit XOR data bit, then CRC = (CRC<<1) XOR (feedback ? polynomial : 0), truncated to the width. The transmit CRC uses the MOSI bits and the receive CRC uses the MISO bits.
- R10: Both CRCs clear to 0 while control bit1 is 0 and on any write to the polynomial register.
- R11: irq is 1 exactly when control bit6 is 1 and the transmit buffer is empty, following them with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Transmit-buffer-empty interrupt |

## Verification
Frames run against a slave model that shifts a different known word back. This shows whether MOSI and MISO are kept apart, whether bits go MSB first, and whether a data read returns the received word rather than the written one. The patterns 0xA5 and 0x3C in 8-bit mode and 0xC3A5 in 16-bit mode separate the two widths and expose a wrong truncation. Clock codes 0, 2 and 7 separate divisor errors by a factor of two. Back-to-back words, gated starts, polynomial rewrites and a disable show that the TXE, RXNE and CRC state changes only when it should.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CODE_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_POLY  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXCRC = 3'd4;
  localparam logic [ADDR_W-1:0] A_TXCRC = 3'd5;

  localparam logic [DATA_W-1:0] POLY_RESET = 16'h0007;

  typedef struct packed {
    logic              txie;
    logic              wide;
    logic [CODE_W-1:0] code;
    logic              en;
    logic              master;
  } ctrl_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned MAX_SH = (1 << CODE_W) - 1;
  localparam int unsigned CNT_W  = (MAX_SH < 1) ? 1 : MAX_SH;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // half period of SCK is 2^code system clocks
  assign lim  = CNT_W'((1 << code) - 1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame_eng.sv
module spi_frame_eng #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              wide,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              bit_stb,
  output logic              tx_bit,
  output logic              rx_bit
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned BCNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [BCNT_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    done    <= 1'b0;
    bit_stb <= 1'b0;
    if (rst || !en) begin
      sck   <= 1'b0;
      mosi  <= 1'b0;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
      tx_sh <= '0;
      rx_sh <= '0;
      bcnt  <= '0;
      tx_bit <= 1'b0;
      rx_bit <= 1'b0;
      if (rst) rx_word <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cs_n  <= 1'b0;
        sck   <= 1'b0;
        tx_sh <= wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
        mosi  <= wide ? tx_word[DATA_W-1] : tx_word[HALF_W-1];
        bcnt  <= wide ? BCNT_W'(DATA_W - 1) : BCNT_W'(HALF_W - 1);
      end
    end else if (tick) begin
      if (!sck) begin
        sck     <= 1'b1;
        rx_sh   <= {rx_sh[DATA_W-2:0], miso};
        bit_stb <= 1'b1;
        tx_bit  <= mosi;
        rx_bit  <= miso;
      end else begin
        sck <= 1'b0;
        if (bcnt == '0) begin
          busy    <= 1'b0;
          cs_n    <= 1'b1;
          mosi    <= 1'b0;
          done    <= 1'b1;
          rx_word <= wide ? rx_sh : {{HALF_W{1'b0}}, rx_sh[HALF_W-1:0]};
        end else begin
          bcnt  <= bcnt - 1'b1;
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          mosi  <= tx_sh[DATA_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/spi_crc_acc.sv
module spi_crc_acc #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic              bit_in,
  input  logic              wide,
  input  logic [DATA_W-1:0] poly,
  output logic [DATA_W-1:0] crc
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic              fb;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    fb  = (wide ? crc[DATA_W-1] : crc[HALF_W-1]) ^ bit_in;
    nxt = {crc[DATA_W-2:0], 1'b0} ^ (fb ? poly : '0);
    if (!wide) nxt[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (step)  crc <= nxt;
  end
endmodule

// File: rtl/spi_crc_master.sv
module spi_crc_master
  import spi_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  localparam int unsigned NCRC = 2;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] txbuf_q, poly_q;
  logic              full_q, rxne_q;
  logic              start, tick, busy, done, bit_stb, tx_bit, rx_bit;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] crc_v [NCRC];
  logic [NCRC-1:0]   crc_bits;
  logic              crc_clr;

  logic wr_ctrl, wr_data, wr_poly, rd_data;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_data = wr_en && (addr == A_DATA);
  assign wr_poly = wr_en && (addr == A_POLY);
  assign rd_data = rd_en && (addr == A_DATA);

  assign start   = ctrl_q.en && ctrl_q.master && full_q && !busy;
  assign crc_clr = !ctrl_q.en || wr_poly;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      poly_q  <= POLY_RESET;
      txbuf_q <= '0;
      full_q  <= 1'b0;
      rxne_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
      if (wr_poly) poly_q <= wdata;
      if (wr_data) begin
        txbuf_q <= wdata;
        full_q  <= 1'b1;
      end else if (start) begin
        full_q  <= 1'b0;
      end
      if (done)         rxne_q <= 1'b1;
      else if (rd_data) rxne_q <= 1'b0;
      irq <= ctrl_q.txie && !full_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTRL:  rdata <= DATA_W'(ctrl_q);
        A_STAT:  rdata <= {13'd0, busy, rxne_q, !full_q};
        A_DATA:  rdata <= rx_word;
        A_POLY:  rdata <= poly_q;
        A_RXCRC: rdata <= crc_v[0];
        A_TXCRC: rdata <= crc_v[1];
        default: rdata <= '0;
      endcase
    end
  end

  spi_baud_gen #(.CODE_W(CODE_W)) baud_i (
    .clk(clk), .rst(rst), .run(busy), .code(ctrl_q.code), .tick(tick)
  );

  spi_frame_eng #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .start(start), .wide(ctrl_q.wide),
    .tx_word(txbuf_q), .tick(tick), .miso(miso), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .done(done), .rx_word(rx_word),
    .bit_stb(bit_stb), .tx_bit(tx_bit), .rx_bit(rx_bit)
  );

  // channel 0 follows MISO, channel 1 follows MOSI
  assign crc_bits = {tx_bit, rx_bit};

  for (genvar g = 0; g < NCRC; g++) begin : g_crc
    spi_crc_acc #(.DATA_W(DATA_W)) acc_i (
      .clk(clk), .rst(rst), .clr(crc_clr), .step(bit_stb),
      .bit_in(crc_bits[g]), .wide(ctrl_q.wide), .poly(poly_q), .crc(crc_v[g])
    );
  end
endmodule

// File: rtl/spi_crc_master_chk.sv
module spi_crc_master_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic txie,
  input logic full,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic done,
  input logic rxne,
  input logic irq
);
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cs_n && !sck));

  p_sck_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(mosi));

  p_rxne_after_frame_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> rxne);

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    (txie && !full) |=> irq);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(txie && !full) |=> !irq);
endmodule

bind spi_crc_master spi_crc_master_chk chk_i (
  .clk(clk), .rst(rst), .en(ctrl_q.en), .txie(ctrl_q.txie), .full(full_q),
  .sck(sck), .cs_n(cs_n), .mosi(mosi), .done(done), .rxne(rxne_q), .irq(irq)
);

// File: tb/spi_crc_master_tb_top.sv
`timescale 1ns/1ps
module spi_crc_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sck, mosi, cs_n, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_crc_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .irq(irq)
  );

  // slave model and line monitor
  logic [15:0] slv_word = 16'h0;
  logic        slv_wide = 1'b0;
  logic [15:0] slv_sh = 16'h0;
  logic [15:0] mosi_cap = 16'h0;
  int          nrise = 0;
  int          nframes = 0;
  realtime     t0 = 0, per = 0;
  logic [15:0] frame_log [4];

  always @(negedge cs_n) begin
    slv_sh   = slv_wide ? slv_word : {slv_word[7:0], 8'h00};
    miso     = slv_sh[15];
    mosi_cap = 16'h0;
    nrise    = 0;
  end
  always @(negedge sck) begin
    if (!cs_n) begin
      slv_sh = {slv_sh[14:0], 1'b0};
      miso   = slv_sh[15];
    end
  end
  always @(posedge sck) begin
    if (nrise == 0) t0 = $realtime;
    if (nrise == 1) per = $realtime - t0;
    mosi_cap = {mosi_cap[14:0], mosi};
    nrise++;
  end
  always @(posedge cs_n) begin
    frame_log[nframes % 4] = mosi_cap;
    nframes++;
  end

  // expected CRC state
  logic [15:0] exp_tx = 16'h0, exp_rx = 16'h0, exp_poly = 16'h0007;

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d,
                                          input logic wide, input logic [15:0] p);
    int n = wide ? 16 : 8;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = (wide ? c[15] : c[7]) ^ d[i];
      c = {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
      if (!wide) c[15:8] = 8'h0;
    end
    return c;
  endfunction

  function automatic logic [15:0] cw(input logic m, input logic e, input logic [2:0] code,
                                     input logic w, input logic ie);
    return {9'd0, ie, w, code, e, m};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_ctrl(input logic [15:0] c);
    reg_wr(3'd0, c);
    if (!c[1]) begin exp_tx = 0; exp_rx = 0; end
  endtask

  task automatic wait_frame_end();
    @(posedge cs_n);
    repeat (3) @(negedge clk);
  endtask

  // one frame: send tx, slave answers rx
  task automatic xfer(input logic [15:0] tx, input logic [15:0] rx, input logic wide,
                      input string tag);
    logic [15:0] v;
    logic [15:0] mtx = wide ? tx : {8'h0, tx[7:0]};
    logic [15:0] mrx = wide ? rx : {8'h0, rx[7:0]};
    slv_word = rx; slv_wide = wide;
    reg_wr(3'd2, tx);
    wait_frame_end();
    chk(mosi_cap == mtx, {tag, " R4 mosi word"}, mosi_cap, mtx);
    chk(nrise == (wide ? 16 : 8), {tag, " R5 sck pulses"}, nrise, wide ? 16 : 8);
    reg_rd(3'd1, v);
    chk(v[1:0] == 2'b11, {tag, " R8 rxne set"}, v, 3);
    reg_rd(3'd2, v);
    chk(v == mrx, {tag, " R6 rx data"}, v, mrx);
    reg_rd(3'd1, v);
    chk(v[1] == 1'b0, {tag, " R8 rxne cleared"}, v, 1);
    exp_tx = crc_ref(exp_tx, mtx, wide, exp_poly);
    exp_rx = crc_ref(exp_rx, mrx, wide, exp_poly);
  endtask

  task automatic check_crcs(input string tag);
    logic [15:0] v;
    reg_rd(3'd4, v);
    chk(v == exp_rx, {tag, " R9 rx crc"}, v, exp_rx);
    reg_rd(3'd5, v);
    chk(v == exp_tx, {tag, " R9 tx crc"}, v, exp_tx);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(cs_n === 1'b1 && sck === 1'b0 && irq === 1'b0, "R1 pins", {cs_n, sck, irq}, 3'b100);
    reg_rd(3'd0, v); chk(v == 16'h0, "R1 ctrl", v, 0);
    reg_rd(3'd3, v); chk(v == 16'h0007, "R1 poly", v, 16'h0007);
    reg_rd(3'd1, v); chk(v == 16'h0001, "R1 status", v, 1);
    reg_rd(3'd4, v); chk(v == 16'h0, "R1 rx crc", v, 0);
    reg_rd(3'd5, v); chk(v == 16'h0, "R1 tx crc", v, 0);
  endtask

  task automatic t_baud();
    int codes [3] = '{0, 2, 7};
    foreach (codes[i]) begin
      int exp_per = 2 ** (codes[i] + 1);
      set_ctrl(cw(1, 1, codes[i][2:0], 0, 0));
      xfer(16'h00A5, 16'h005A, 1'b0, "baud");
      chk(int'(per / 5.0) == exp_per, "R2 sck period", int'(per / 5.0), exp_per);
      chk(sck == 1'b0, "R2 sck idle low", sck, 0);
    end
    check_crcs("baud");
  endtask

  task automatic t_gate();
    logic [15:0] v;
    set_ctrl(cw(0, 1, 3'd0, 0, 0));
    slv_word = 16'h0011; slv_wide = 1'b0;
    reg_wr(3'd2, 16'h003C);
    repeat (100) @(negedge clk);
    reg_rd(3'd1, v);
    chk(cs_n == 1'b1 && sck == 1'b0 && v[0] == 1'b0, "R3 slave role holds", {cs_n, sck, v[0]}, 3'b100);
    set_ctrl(cw(1, 0, 3'd0, 0, 0));
    repeat (100) @(negedge clk);
    reg_rd(3'd1, v);
    chk(cs_n == 1'b1 && v[0] == 1'b0, "R3 disabled holds", {cs_n, v[0]}, 2'b10);
    set_ctrl(cw(1, 1, 3'd1, 0, 0));
    wait_frame_end();
    chk(mosi_cap == 16'h003C, "R3 buffered word sent", mosi_cap, 16'h003C);
    reg_rd(3'd2, v);
    chk(v == 16'h0011, "R6 rx not tx", v, 16'h0011);
    exp_tx = crc_ref(exp_tx, 16'h003C, 1'b0, exp_poly);
    exp_rx = crc_ref(exp_rx, 16'h0011, 1'b0, exp_poly);
    check_crcs("gate");
  endtask

  task automatic t_wide();
    logic [15:0] v;
    reg_wr(3'd3, 16'h1021);
    exp_poly = 16'h1021; exp_tx = 0; exp_rx = 0;
    set_ctrl(cw(1, 1, 3'd1, 1, 0));
    xfer(16'hC3A5, 16'h8E71, 1'b1, "wide");
    xfer(16'h0F0F, 16'hFFFF, 1'b1, "wide2");
    check_crcs("wide");
    reg_rd(3'd1, v);
    chk(v[0] == 1'b1, "R7 txe after frames", v, 1);
  endtask

  task automatic t_b2b();
    logic [15:0] v;
    int n0;
    set_ctrl(cw(1, 1, 3'd2, 0, 0));
    slv_word = 16'h0066; slv_wide = 1'b0;
    n0 = nframes;
    reg_wr(3'd2, 16'h0081);
    @(negedge cs_n);
    repeat (2) @(negedge clk);
    reg_rd(3'd1, v);
    chk(v[0] == 1'b1 && v[2] == 1'b1, "R7 txe during frame", v, 5);
    reg_wr(3'd2, 16'h007E);
    wait (nframes == n0 + 2);
    repeat (3) @(negedge clk);
    chk(frame_log[n0 % 4] == 16'h0081, "R7 first frame", frame_log[n0 % 4], 16'h0081);
    chk(frame_log[(n0 + 1) % 4] == 16'h007E, "R7 second frame", frame_log[(n0 + 1) % 4], 16'h007E);
    reg_rd(3'd2, v);
    exp_tx = crc_ref(crc_ref(exp_tx, 16'h0081, 1'b0, exp_poly), 16'h007E, 1'b0, exp_poly);
    exp_rx = crc_ref(crc_ref(exp_rx, 16'h0066, 1'b0, exp_poly), 16'h0066, 1'b0, exp_poly);
    check_crcs("b2b");
  endtask

  task automatic t_crc_clear();
    logic [15:0] v;
    reg_wr(3'd3, 16'h0007);
    exp_poly = 16'h0007;
    reg_rd(3'd4, v); chk(v == 16'h0, "R10 rx crc after poly write", v, 0);
    reg_rd(3'd5, v); chk(v == 16'h0, "R10 tx crc after poly write", v, 0);
    exp_tx = 0; exp_rx = 0;
    xfer(16'h00F0, 16'h0033, 1'b0, "clr");
    check_crcs("clr");
    set_ctrl(cw(1, 0, 3'd2, 0, 0));
    reg_rd(3'd5, v); chk(v == 16'h0, "R10 tx crc after disable", v, 0);
  endtask

  task automatic t_irq();
    set_ctrl(cw(0, 1, 3'd0, 0, 1));
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R11 irq empty", irq, 1);
    reg_wr(3'd2, 16'h0055);
    @(negedge clk);
    chk(irq == 1'b0, "R11 irq full", irq, 0);
    set_ctrl(cw(0, 1, 3'd0, 0, 0));
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_baud();
    t_gate();
    t_wide();
    t_b2b();
    t_crc_clear();
    t_irq();
    finish_run();
  end

  initial begin
    #(5 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule